// File: doc/BRIEF.md
# Display Source Selector with Hold and Peak

This block chooses the value that a numeric display shows. Four sources compete for the display data register: the latest signed conversion result, a running peak of those results, a word written by the host, and the register's own frozen value. A fifth path bypasses the register entirely and sends four host-written raw segment bytes straight to the 32-bit segment vector. Control bits, the host word and the raw segment bytes arrive as parallel register writes. A write counts only while the active-low chip-select is low.

The peak register keeps tracking every conversion, even while the display is frozen. A clear request is armed by a control write and takes effect only when chip-select returns high. A small state machine follows chip-select through three states: `CS_IDLE` (deselected), `CS_SELECTED` (selected, nothing armed) and `CS_ARMED` (selected, clear armed). It has these transitions:

- idle-to-selected: chip-select falls.
- selected-to-armed (also taken straight from idle): a control write with the clear bit set.
- armed-stays-armed: chip-select stays low.
- release: chip-select rises, from either selected state back to idle.

Leaving `CS_ARMED` through release fires the clear. The display source is decoded each cycle in priority order: `SRC_HOST`, `SRC_HOLD`, `SRC_PEAK`, `SRC_LIVE`.

Top module: `disp_src_sel`

## Requirements
- R1: After reset, `disp_word` is 0, `seg_out` is 0 and `disp_upd` is 0. Every control bit is 0.
- R2: With every mode bit 0, a `conv_valid` pulse loads `conv_data` into `disp_word` at that clock edge. When the raw bit is 0, `seg_out` is `{16'h0000, disp_word}`.
- R3: When the host bit (control bit 0) is 1, `disp_word` takes the host word (address 1) one clock later. This overrides hold, peak and conversions.
- R4: When the hold bit (control bit 1) is 1 and the host bit is 0, `disp_word` does not change, even on `conv_valid` pulses.
- R5: The peak register holds the largest signed result seen since reset or clear, and it updates during hold. When the peak bit (control bit 2) is 1 and the host and hold bits are 0, `disp_word` takes the peak value one clock later.
- R6: When the raw bit (control bit 3) is 1, `seg_out` is `{seg3, seg2, seg1, seg0}`, where segment byte k is written at address 2+k, bits 7:0. In this mode `seg_out` does not depend on `disp_word`.
- R7: `disp_upd` is 1 for exactly the cycle after an edge at which `disp_word` changed value. A reload with the same value gives no pulse.
- R8: A write is accepted only when `wr_en` is 1 and `csn` is 0. A write while `csn` is 1 has no effect.
- R9: A control write with bit 4 set arms a clear. At the first clock where `csn` is high again, every register returns to its reset value: control, host word, segment bytes, peak and display. No update pulse is given. Until then, nothing changes.
- R10: The first conversion after reset or clear always becomes the peak, even if it is negative. Before any conversion, the peak reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn | input | 1 | Active-low chip-select for register writes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 host word, 2..5 segment bytes |
| wr_data | input | 16 | Register write data |
| conv_valid | input | 1 | New conversion result strobe |
| conv_data | input | 16 | Conversion result, two's complement |
| disp_word | output | 16 | Display data register |
| disp_upd | output | 1 | One-cycle pulse after the display register changes |
| seg_out | output | 32 | Segment vector |

## Verification
The live path is driven with a repeated value, a negative value and rising and falling positives. These separate real update pulses from reloads and confirm that signed data passes through unchanged. Peak mode is entered after a mix of smaller and larger results, and a conversion is sent while hold is set; the peak must track it while the display stays frozen. Layered modes are stacked: host over hold and peak, then raw over host, with the host word changed underneath, which shows that each higher level hides the lower ones. Writes with chip-select high, a clear armed while still selected, and a negative first sample after clear probe the gating, the deferral and the empty-peak case.

// File: rtl/dss_pkg.sv
package dss_pkg;
    typedef enum logic [1:0] {CS_IDLE, CS_SELECTED, CS_ARMED} cs_state_e;
    typedef enum logic [1:0] {SRC_LIVE, SRC_PEAK, SRC_HOLD, SRC_HOST} src_mode_e;

    typedef struct packed {
        logic raw;
        logic peak;
        logic hold;
        logic host;
    } ctrl_t;

    localparam int CTRL_BITS = 4;
    localparam int CTRL_CLR  = 4;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_HOST = 1;
    localparam int SEG_BASE  = 2;
endpackage

// File: rtl/dss_regs.sv
module dss_regs
    import dss_pkg::*;
#(
    parameter int DW    = 16,
    parameter int SEG_W = 8,
    parameter int SEG_N = 4,
    parameter int AW    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   csn,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    output ctrl_t                  ctrl,
    output logic [DW-1:0]          host_word,
    output logic [SEG_N*SEG_W-1:0] seg_flat,
    output logic                   clr_fire
);
    localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);
    localparam logic [AW-1:0] A_HOST = AW'(ADDR_HOST);

    cs_state_e state, nxt;
    logic      wr_ok, clr_wr;

    assign wr_ok  = wr_en && !csn;
    assign clr_wr = wr_ok && (wr_addr == A_CTRL) && wr_data[CTRL_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            CS_IDLE, CS_SELECTED: nxt = csn ? CS_IDLE : (clr_wr ? CS_ARMED : CS_SELECTED);
            CS_ARMED:             nxt = csn ? CS_IDLE : CS_ARMED;
            default:              nxt = CS_IDLE;
        endcase
    end

    always_comb begin
        clr_fire = (state == CS_ARMED) && csn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            host_word <= '0;
        end else if (clr_fire) begin
            ctrl      <= '0;
            host_word <= '0;
        end else if (wr_ok) begin
            if (wr_addr == A_CTRL) ctrl      <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
            if (wr_addr == A_HOST) host_word <= wr_data;
        end
    end

    for (genvar k = 0; k < SEG_N; k++) begin : g_seg
        localparam logic [AW-1:0] A_SEG = AW'(SEG_BASE + k);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          seg_flat[k*SEG_W +: SEG_W] <= '0;
            else if (clr_fire)                   seg_flat[k*SEG_W +: SEG_W] <= '0;
            else if (wr_ok && wr_addr == A_SEG)  seg_flat[k*SEG_W +: SEG_W] <= wr_data[SEG_W-1:0];
        end
    end

    // R9: registers are zero on the cycle after the deferred clear fires
    assert_deferred_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> (ctrl == '0) && (host_word == '0) && (seg_flat == '0));

    // R8: deselected bus leaves the register contents unchanged
    assert_cs_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csn && !clr_fire) |=> ($stable(ctrl) && $stable(host_word) && $stable(seg_flat)));
endmodule

// File: rtl/dss_peak.sv
module dss_peak #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          conv_valid,
    input  logic [DW-1:0] conv_data,
    output logic [DW-1:0] peak_q
);
    logic seen;
    logic take;

    assign take = conv_valid && (!seen || ($signed(conv_data) > $signed(peak_q)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peak_q <= '0;
            seen   <= 1'b0;
        end else if (clr) begin
            peak_q <= '0;
            seen   <= 1'b0;
        end else if (take) begin
            peak_q <= conv_data;
            seen   <= 1'b1;
        end
    end

    // R5: once a sample is held, the peak never falls until clear
    assert_peak_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !clr) |=> ($signed(peak_q) >= $signed($past(peak_q))));

    // R10: first sample after reset or clear is taken whatever its sign
    assert_first_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen && conv_valid && !clr) |=> (peak_q == $past(conv_data)));
endmodule

// File: rtl/dss_disp.sv
module dss_disp
    import dss_pkg::*;
#(
    parameter int DW    = 16,
    parameter int SEG_W = 8,
    parameter int SEG_N = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  ctrl_t                  ctrl,
    input  logic [DW-1:0]          host_word,
    input  logic [DW-1:0]          peak_word,
    input  logic                   conv_valid,
    input  logic [DW-1:0]          conv_data,
    input  logic [SEG_N*SEG_W-1:0] seg_flat,
    output logic [DW-1:0]          disp_q,
    output logic                   disp_upd,
    output logic [SEG_N*SEG_W-1:0] seg_out
);
    localparam int OW = SEG_N * SEG_W;

    src_mode_e     src;
    logic [DW-1:0] disp_nxt;

    always_comb begin
        if (ctrl.host)      src = SRC_HOST;
        else if (ctrl.hold) src = SRC_HOLD;
        else if (ctrl.peak) src = SRC_PEAK;
        else                src = SRC_LIVE;
    end

    always_comb begin
        unique case (src)
            SRC_HOST: disp_nxt = host_word;
            SRC_HOLD: disp_nxt = disp_q;
            SRC_PEAK: disp_nxt = peak_word;
            SRC_LIVE: disp_nxt = conv_valid ? conv_data : disp_q;
            default:  disp_nxt = disp_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_q   <= '0;
            disp_upd <= 1'b0;
        end else if (clr) begin
            disp_q   <= '0;
            disp_upd <= 1'b0;
        end else begin
            disp_q   <= disp_nxt;
            disp_upd <= (disp_nxt != disp_q);
        end
    end

    always_comb begin
        seg_out = ctrl.raw ? seg_flat : {{(OW-DW){1'b0}}, disp_q};
    end

    // R4: a frozen display keeps its value across the next edge
    assert_hold_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_HOLD && !clr) |=> $stable(disp_q));

    // R3: the host word reaches the display one edge later
    assert_host_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_HOST && !clr) |=> (disp_q == $past(host_word)));

    // R7: the update pulse only follows a real change
    assert_upd_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_upd |-> (disp_q != $past(disp_q)));
endmodule

// File: rtl/disp_src_sel.sv
module disp_src_sel
    import dss_pkg::*;
#(
    parameter int DW    = 16,
    parameter int SEG_W = 8,
    parameter int SEG_N = 4,
    parameter int AW    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   csn,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic                   conv_valid,
    input  logic [DW-1:0]          conv_data,
    output logic [DW-1:0]          disp_word,
    output logic                   disp_upd,
    output logic [SEG_N*SEG_W-1:0] seg_out
);
    ctrl_t                  ctrl;
    logic [DW-1:0]          host_word;
    logic [DW-1:0]          peak_word;
    logic [SEG_N*SEG_W-1:0] seg_flat;
    logic                   clr_fire;

    dss_regs #(.DW(DW), .SEG_W(SEG_W), .SEG_N(SEG_N), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .csn(csn), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ctrl(ctrl),
        .host_word(host_word), .seg_flat(seg_flat), .clr_fire(clr_fire)
    );

    dss_peak #(.DW(DW)) u_peak (
        .clk(clk), .rst_n(rst_n), .clr(clr_fire), .conv_valid(conv_valid),
        .conv_data(conv_data), .peak_q(peak_word)
    );

    dss_disp #(.DW(DW), .SEG_W(SEG_W), .SEG_N(SEG_N)) u_disp (
        .clk(clk), .rst_n(rst_n), .clr(clr_fire), .ctrl(ctrl),
        .host_word(host_word), .peak_word(peak_word), .conv_valid(conv_valid),
        .conv_data(conv_data), .seg_flat(seg_flat), .disp_q(disp_word),
        .disp_upd(disp_upd), .seg_out(seg_out)
    );
endmodule

// File: tb/disp_src_sel_test.sv
`timescale 1ns/1ps
module disp_src_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        conv_valid = 1'b0;
    logic [15:0] conv_data = '0;
    logic [15:0] disp_word;
    logic        disp_upd;
    logic [31:0] seg_out;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string phase = "R1";

    always #4 clk = ~clk;

    disp_src_sel uut (
        .clk(clk), .rst_n(rst_n), .csn(csn), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .conv_valid(conv_valid), .conv_data(conv_data),
        .disp_word(disp_word), .disp_upd(disp_upd), .seg_out(seg_out)
    );

    // behavioural reference model
    logic [3:0]  m_ctrl;
    logic [15:0] m_host, m_peak, m_disp, m_nd;
    logic        m_seen, m_upd, m_armed;
    logic [7:0]  m_seg [4];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 0; m_host = 0; m_peak = 0; m_disp = 0;
            m_seen = 0; m_upd = 0; m_armed = 0;
            for (int i = 0; i < 4; i++) m_seg[i] = 0;
        end else if (m_armed && csn) begin
            m_ctrl = 0; m_host = 0; m_peak = 0; m_disp = 0;
            m_seen = 0; m_upd = 0; m_armed = 0;
            for (int i = 0; i < 4; i++) m_seg[i] = 0;
        end else begin
            if (m_ctrl[0])      m_nd = m_host;
            else if (m_ctrl[1]) m_nd = m_disp;
            else if (m_ctrl[2]) m_nd = m_peak;
            else if (conv_valid) m_nd = conv_data;
            else                m_nd = m_disp;
            m_upd  = (m_nd != m_disp);
            m_disp = m_nd;
            if (conv_valid && (!m_seen || $signed(conv_data) > $signed(m_peak))) begin
                m_peak = conv_data;
                m_seen = 1;
            end
            if (!csn && wr_en) begin
                if (wr_addr == 0) m_ctrl = wr_data[3:0];
                else if (wr_addr == 1) m_host = wr_data;
                else if (wr_addr >= 2 && wr_addr <= 5) m_seg[wr_addr - 2] = wr_data[7:0];
            end
            m_armed = csn ? 1'b0 : (m_armed || (wr_en && wr_addr == 0 && wr_data[4]));
        end
    end

    function automatic logic [31:0] m_seg_out();
        return m_ctrl[3] ? {m_seg[3], m_seg[2], m_seg[1], m_seg[0]} : {16'h0000, m_disp};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase, "model disp_word", {16'h0, disp_word}, {16'h0, m_disp});
            check(phase, "model disp_upd", {31'h0, disp_upd}, {31'h0, m_upd});
            check(phase, "model seg_out", seg_out, m_seg_out());
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        csn = 1'b0; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic conv(input logic [15:0] d);
        conv_valid = 1'b1; conv_data = d;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        check("R1", "reset disp", {16'h0, disp_word}, 32'h0);
        check("R1", "reset seg", seg_out, 32'h0);
        check("R1", "reset upd", {31'h0, disp_upd}, 32'h0);

        phase = "R2";
        conv(16'h0123);
        check("R2", "live load", {16'h0, disp_word}, 32'h0123);
        check("R7", "upd on change", {31'h0, disp_upd}, 32'h1);
        tick();
        check("R7", "upd one cycle", {31'h0, disp_upd}, 32'h0);
        conv(16'h0123);
        check("R7", "no upd on same value", {31'h0, disp_upd}, 32'h0);
        conv(16'hFFFB);
        check("R2", "signed seg_out", seg_out, 32'h0000FFFB);
        conv(16'h0400);
        conv(16'h0200);

        phase = "R5";
        wr(0, 16'h0004);
        tick();
        check("R5", "peak shown", {16'h0, disp_word}, 32'h0400);

        phase = "R4";
        wr(0, 16'h0006);
        tick();
        conv(16'h7000);
        check("R4", "hold freezes", {16'h0, disp_word}, 32'h0400);
        tick();
        check("R4", "hold still frozen", {16'h0, disp_word}, 32'h0400);
        phase = "R5";
        wr(0, 16'h0004);
        tick();
        check("R5", "peak tracked during hold", {16'h0, disp_word}, 32'h7000);

        phase = "R3";
        wr(1, 16'hBEEF);
        wr(0, 16'h0007);
        tick();
        check("R3", "host overrides", {16'h0, disp_word}, 32'hBEEF);

        phase = "R6";
        wr(2, 16'h0011); wr(3, 16'h0022); wr(4, 16'h0033); wr(5, 16'h0044);
        wr(0, 16'h0009);
        check("R6", "raw segments", seg_out, 32'h44332211);
        wr(1, 16'h1234);
        tick();
        check("R6", "raw ignores display", seg_out, 32'h44332211);
        check("R3", "host under raw", {16'h0, disp_word}, 32'h1234);

        phase = "R8";
        csn = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0000;
        tick();
        wr_en = 1'b0;
        tick();
        check("R8", "deselected write ignored", seg_out, 32'h44332211);

        phase = "R9";
        wr(0, 16'h0018);
        tick();
        check("R9", "clear deferred", seg_out, 32'h44332211);
        csn = 1'b1;
        tick();
        check("R9", "clear disp", {16'h0, disp_word}, 32'h0);
        check("R9", "clear seg", seg_out, 32'h0);
        check("R9", "clear no upd", {31'h0, disp_upd}, 32'h0);

        phase = "R10";
        wr(0, 16'h0004);
        tick();
        check("R10", "empty peak", {16'h0, disp_word}, 32'h0);
        conv(16'hFF9C);
        tick();
        check("R10", "negative first peak", {16'h0, disp_word}, 32'hFF9C);
        conv(16'hFF00);
        tick();
        check("R10", "smaller not taken", {16'h0, disp_word}, 32'hFF9C);
        csn = 1'b1;
        tick();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule